// File: doc/BRIEF.md
# Logic Analyzer Capture Sequencer

This block runs one acquisition of a multi-channel sampler. A host programs it through a byte-wide register port, which is normally driven by a serial management link. The host sets a total sample count, a pre-trigger sample count and a 16-bit clock divisor. It then writes a start code to the run register. While a capture is active, the block derives a one-cycle sample-enable strobe from the 200 MHz base clock. It counts the samples written before and after a trigger pulse, which a separate trigger detector supplies.

The host polls a status byte to follow the capture. The byte holds two 2-bit fields: one for the recording/finished phase and one for waiting/triggered. When the capture has finished, the host reads three 32-bit result words through the sampling address range: the number of samples stored, the number of samples stored before the trigger, and the final write position.

A streaming mode skips the trigger wait. In that mode the capture records the total count at once.

Top module: `cap_seq_top`

## Requirements
- R1: After reset the status byte at address 0x00 reads 0x00, the capture-mode byte at 0x03 reads 0x00, every result byte at 0x10 to 0x1B reads 0x00, and no sample strobe is produced.
- R2: Writing 3 to address 0x00 starts a capture and clears all three result words. Writing 0 stops the capture: the status returns to 0x00 and the result words keep their values. A strobe in the same cycle as the stop write is not counted. A write of any other value to 0x00 has no effect.
- R3: Status byte bits [1:0] read 2 while recording, 1 once finished and 0 when idle. Bits [3:2] read 0 while waiting for the trigger and 3 once triggered. Bits [7:4] read 0. This gives 0x02 while waiting, 0x0E after the trigger and 0x0D when finished.
- R4: In memory mode a trigger pulse accepted while waiting moves the capture to the triggered state. A strobe in the trigger cycle counts as a pre-trigger sample. Pre-trigger samples are counted up to a limit. The limit is the pre-trigger field's low 32 bits or the total count, whichever is smaller.
- R5: The divisor is written little-endian at 0x1E (low byte) and 0x1F (high byte). While a capture is active, the strobe is high for one cycle out of every N cycles, where N is the divisor, or 1 when the divisor is 0. The first strobe comes in the Nth cycle after the start write is taken.
- R6: After the trigger, the capture records exactly total minus pre-trigger-count further strobes. It then finishes with status 0x0D, produces no further strobes, and holds its result words.
- R7: The result words are read little-endian: samples stored at 0x10 to 0x13, pre-trigger samples at 0x14 to 0x17, and the write position at 0x18 to 0x1B. The write position is the number of strobes counted since the start.
- R8: Configuration is written little-endian as follows:
  - The total count goes to 0x10 to 0x13.
  - A 48-bit pre-trigger field goes to 0x14 to 0x19. Bytes 0x18 and 0x19 are ignored.
  - A 32-bit memory split value goes to 0x1A to 0x1D and is ignored.
- R9: Capture-mode bit 0 at 0x03 reads back as written. When it is 1 (streaming), a start goes directly to status 0x0E with zero pre-trigger samples and finishes after the total count of strobes. With a total of 0, the capture finishes in the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 8 | Register byte address for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| trig_in | input | 1 | Trigger pulse from the trigger detector |
| sample_en | output | 1 | One-cycle sample-enable strobe |

## Verification
The assertions assume the host leaves the configuration and mode registers alone while a capture is active. They also assume that only a write changes the run state. Their windows are guarded by the absence of a register write, so that a start or stop edge is not mistaken for a fault. The stimulus programs each capture only while the block is idle or finished. It pulses the trigger only while the capture waits. It counts strobes at the port, except in a cycle that carries a run-register write.

// File: rtl/cap_seq_pkg.sv
// Package: shared register addresses, run codes and capture states
// for the capture sequencer. Assumes a byte-wide register port.
package cap_seq_pkg;
    localparam int ADDR_W  = 8;
    localparam int BYTE_W  = 8;

    localparam logic [ADDR_W-1:0] A_RUN     = 8'h00;
    localparam logic [ADDR_W-1:0] A_MODE    = 8'h03;
    localparam logic [ADDR_W-1:0] A_TOTAL   = 8'h10;
    localparam logic [ADDR_W-1:0] A_PRE     = 8'h14;
    localparam logic [ADDR_W-1:0] A_DIV     = 8'h1E;
    localparam logic [ADDR_W-1:0] A_RES_TOT = 8'h10;
    localparam logic [ADDR_W-1:0] A_RES_PRE = 8'h14;
    localparam logic [ADDR_W-1:0] A_RES_POS = 8'h18;

    localparam logic [BYTE_W-1:0] RUN_GO   = 8'd3;
    localparam logic [BYTE_W-1:0] RUN_HALT = 8'd0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cap_state_t;
endpackage

// File: rtl/cap_seq_regs.sv
// Register file: decodes byte writes into run pulses and configuration
// fields, and multiplexes status, mode and result bytes onto the read
// data. Assumes CNT_W and DIV_W are multiples of the byte width.
module cap_seq_regs
    import cap_seq_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              run_start,
    output logic              run_stop,
    output logic              mode_stream,
    output logic [CNT_W-1:0]  cfg_total,
    output logic [CNT_W-1:0]  cfg_pre,
    output logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        stat_phase,
    input  logic [1:0]        stat_trig,
    input  logic [CNT_W-1:0]  res_total,
    input  logic [CNT_W-1:0]  res_pre,
    input  logic [CNT_W-1:0]  res_pos,
    output logic [BYTE_W-1:0] rdata
);
    localparam int CNT_BYTES = CNT_W / BYTE_W;
    localparam int DIV_BYTES = DIV_W / BYTE_W;

    // Run codes: only the two defined codes produce a pulse.
    assign run_start = wr && (addr == A_RUN) && (wdata == RUN_GO);
    assign run_stop  = wr && (addr == A_RUN) && (wdata == RUN_HALT);

    // Capture-mode bit store.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_stream <= 1'b0;
        else if (wr && addr == A_MODE)
            mode_stream <= wdata[0];
    end

    // Byte lanes for the total and pre-trigger counts.
    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt_lane
        // Total-count lane b.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_total[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr && addr == ADDR_W'(A_TOTAL + b))
                cfg_total[b*BYTE_W +: BYTE_W] <= wdata;
        end
        // Pre-trigger lane b; higher bytes of the field are dropped.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_pre[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr && addr == ADDR_W'(A_PRE + b))
                cfg_pre[b*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    // Byte lanes for the divisor.
    for (genvar d = 0; d < DIV_BYTES; d++) begin : g_div_lane
        // Divisor lane d.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_div[d*BYTE_W +: BYTE_W] <= '0;
            else if (wr && addr == ADDR_W'(A_DIV + d))
                cfg_div[d*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    // Read multiplexer for status, mode and result bytes.
    always_comb begin
        rdata = '0;
        if (addr == A_RUN)
            rdata = {4'b0000, stat_trig, stat_phase};
        if (addr == A_MODE)
            rdata = {7'b0000000, mode_stream};
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (addr == ADDR_W'(A_RES_TOT + b))
                rdata = res_total[b*BYTE_W +: BYTE_W];
            if (addr == ADDR_W'(A_RES_PRE + b))
                rdata = res_pre[b*BYTE_W +: BYTE_W];
            if (addr == ADDR_W'(A_RES_POS + b))
                rdata = res_pos[b*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/cap_seq_clkdiv.sv
// Sample-rate divider: while enabled, produces a one-cycle strobe every
// max(div,1) base cycles. A restart pulse realigns the phase to zero.
module cap_seq_clkdiv #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             strobe
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] wrap_at;

    // Last count value before wrap; a divisor of 0 behaves as 1.
    assign wrap_at = (div == '0) ? '0 : div - 1'b1;
    assign strobe  = en && (cnt == wrap_at);

    // Phase counter, held at zero while disabled or restarting.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !en)
            cnt <= '0;
        else if (cnt == wrap_at)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cap_seq_ctrl.sv
// Capture controller: run state machine plus pre-trigger, post-trigger
// and write-position counters. Assumes the configuration stays constant
// while a capture is active.
module cap_seq_ctrl
    import cap_seq_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             stream,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] pre,
    input  logic             strobe,
    input  logic             trig,
    output logic             active,
    output logic [1:0]       phase,
    output logic [1:0]       trig_st,
    output logic [CNT_W-1:0] pre_lim,
    output logic [CNT_W-1:0] n_pre,
    output logic [CNT_W-1:0] n_post,
    output logic [CNT_W-1:0] n_pos
);
    cap_state_t       state;
    logic [CNT_W-1:0] post_lim;
    logic             pre_take;
    logic [CNT_W-1:0] n_pre_nx;
    logic [CNT_W-1:0] remain;

    // Pre-trigger limit clamped to the total count.
    assign pre_lim  = (pre < total) ? pre : total;
    assign pre_take = strobe && (n_pre < pre_lim);
    assign n_pre_nx = n_pre + CNT_W'(pre_take);
    assign remain   = total - n_pre_nx;

    assign active  = (state == ST_WAIT) || (state == ST_POST);
    assign phase   = active ? 2'd2 : (state == ST_DONE) ? 2'd1 : 2'd0;
    assign trig_st = (state == ST_POST || state == ST_DONE) ? 2'd3 : 2'd0;

    // Run state and sample counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            n_pre    <= '0;
            n_post   <= '0;
            n_pos    <= '0;
            post_lim <= '0;
        end else if (start) begin
            n_pre    <= '0;
            n_post   <= '0;
            n_pos    <= '0;
            post_lim <= total;
            if (!stream)
                state <= ST_WAIT;
            else if (total == '0)
                state <= ST_DONE;
            else
                state <= ST_POST;
        end else if (stop) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (strobe)
                        n_pos <= n_pos + 1'b1;
                    n_pre <= n_pre_nx;
                    if (trig) begin
                        post_lim <= remain;
                        state    <= (remain == '0) ? ST_DONE : ST_POST;
                    end
                end
                ST_POST: begin
                    if (strobe) begin
                        n_pos  <= n_pos + 1'b1;
                        n_post <= n_post + 1'b1;
                        if (n_post + 1'b1 == post_lim)
                            state <= ST_DONE;
                    end
                end
                default: state <= state;
            endcase
        end
    end
endmodule

// File: rtl/cap_seq_top.sv
// Capture sequencer top: joins the register file, the sample-rate
// divider and the capture controller. Assumes a single clock domain.
module cap_seq_top
    import cap_seq_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              trig_in,
    output logic              sample_en
);
    logic             run_start;
    logic             run_stop;
    logic             mode_stream;
    logic [CNT_W-1:0] cfg_total;
    logic [CNT_W-1:0] cfg_pre;
    logic [DIV_W-1:0] cfg_div;
    logic             cap_active;
    logic [1:0]       phase;
    logic [1:0]       trig_st;
    logic [CNT_W-1:0] pre_lim;
    logic [CNT_W-1:0] n_pre;
    logic [CNT_W-1:0] n_post;
    logic [CNT_W-1:0] n_pos;
    logic [CNT_W-1:0] n_stored;

    assign n_stored = n_pre + n_post;

    cap_seq_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .run_start(run_start), .run_stop(run_stop),
        .mode_stream(mode_stream), .cfg_total(cfg_total),
        .cfg_pre(cfg_pre), .cfg_div(cfg_div), .stat_phase(phase),
        .stat_trig(trig_st), .res_total(n_stored), .res_pre(n_pre),
        .res_pos(n_pos), .rdata(reg_rdata)
    );

    cap_seq_clkdiv #(.DIV_W(DIV_W)) i_div (
        .clk(clk), .rst_n(rst_n), .en(cap_active), .restart(run_start),
        .div(cfg_div), .strobe(sample_en)
    );

    cap_seq_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(run_start), .stop(run_stop),
        .stream(mode_stream), .total(cfg_total), .pre(cfg_pre),
        .strobe(sample_en), .trig(trig_in), .active(cap_active),
        .phase(phase), .trig_st(trig_st), .pre_lim(pre_lim),
        .n_pre(n_pre), .n_post(n_post), .n_pos(n_pos)
    );
endmodule

// File: rtl/cap_seq_chk.sv
// Checker for the capture sequencer, attached to the top by bind.
// Assumes configuration is static during an active capture.
module cap_seq_chk #(
    parameter int CNT_W = 32,
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             sample_en,
    input logic             cap_active,
    input logic [DIV_W-1:0] cfg_div,
    input logic [CNT_W-1:0] n_pre,
    input logic [CNT_W-1:0] pre_lim,
    input logic [CNT_W-1:0] n_pos,
    input logic [1:0]       phase
);
    assert_strobe_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && cfg_div > 1 && !reg_wr) |=> !sample_en);

    assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_active |-> (n_pre <= pre_lim));

    assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'b11);

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && !reg_wr) |=> (phase == 2'd1 && $stable(n_pos)));

    assert_pos_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !reg_wr) |=> $stable(n_pos));
endmodule

bind cap_seq_top cap_seq_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .sample_en(sample_en),
    .cap_active(cap_active), .cfg_div(cfg_div), .n_pre(n_pre),
    .pre_lim(pre_lim), .n_pos(n_pos), .phase(phase)
);

// File: tb/test_cap_seq_top.sv
`timescale 1ns/1ps
module test_cap_seq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       trig_in = 1'b0;
    logic       sample_en;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit summary_done = 0;

    always #2 clk = ~clk;

    cap_seq_top i_cap_seq_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
        .sample_en(sample_en)
    );

    // Port-level strobe count; a strobe in a run-write cycle is not counted (R2).
    always @(negedge clk)
        if (sample_en && !(reg_wr && reg_addr == 8'h00)) strobes++;

    // Vector table: divisor, total, pre-trigger field, strobes before trigger.
    localparam int NV = 6;
    localparam int V_DIV [NV] = '{1, 0, 3, 2, 1, 2};
    localparam int V_TOT [NV] = '{10, 8, 6, 12, 5, 4};
    localparam int V_PRE [NV] = '{3, 8, 2, 20, 2, 0};
    localparam int V_K   [NV] = '{5, 2, 0, 4, 1, 3};

    task automatic check(input string tag, input longint got, input longint exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr_n(input logic [7:0] base, input int nb, input longint v);
        for (int b = 0; b < nb; b++) wr(8'(base + b), 8'(v >> (8*b)));
    endtask

    task automatic rd32(input logic [7:0] base, output longint v);
        logic [7:0] d;
        v = 0;
        for (int b = 0; b < 4; b++) begin
            rd(8'(base + b), d);
            v = v | (longint'(d) << (8*b));
        end
    endtask

    task automatic start_cap();
        #1 strobes = 0;
        wr(8'h00, 8'h03);
    endtask

    task automatic wait_done(output bit ok);
        logic [7:0] s;
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            rd(8'h00, s);
            if (s[1:0] == 2'd1) begin ok = 1; break; end
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!summary_done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            summary_done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        longint v, t, p;
        bit ok;
        int seen, pre_seen, lim, npre;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        rd(8'h00, s); check("R1 status", s, 8'h00);
        rd(8'h03, s); check("R1 mode", s, 0);
        rd32(8'h10, v); check("R1 stored", v, 0);
        rd32(8'h14, v); check("R1 pre", v, 0);
        rd32(8'h18, v); check("R1 pos", v, 0);
        check("R1 no strobe", strobes, 0);

        // R2: unknown run code ignored.
        wr(8'h00, 8'h05);
        rd(8'h00, s); check("R2 other code", s, 8'h00);

        // R2/R5: start with divisor 0, strobe in first cycle, then stop.
        wr_n(8'h10, 4, 100);
        start_cap();
        check("R5 div0 first strobe", sample_en, 1);
        wr(8'h00, 8'h00);
        rd(8'h00, s); check("R2 stop status", s, 8'h00);
        rd32(8'h18, v); check("R2 pos kept", v, strobes);
        check("R2 one strobe kept", v, 1);

        // R3: waiting status.
        start_cap();
        rd(8'h00, s); check("R3 waiting", s, 8'h02);
        wr(8'h00, 8'h00);

        // R5: divisor 4 spacing.
        wr_n(8'h1E, 2, 4);
        start_cap();
        begin
            int first, second;
            first = -1; second = -1;
            for (int c = 0; c < 9; c++) begin
                if (sample_en) begin
                    if (first < 0) first = c; else if (second < 0) second = c;
                end
                @(negedge clk);
            end
            check("R5 div4 first", first, 3);
            check("R5 div4 second", second, 7);
        end
        wr(8'h00, 8'h00);

        // R9: streaming mode.
        wr(8'h03, 8'h01);
        rd(8'h03, s); check("R9 mode readback", s, 1);
        wr_n(8'h1E, 2, 1);
        wr_n(8'h10, 4, 7);
        start_cap();
        rd(8'h00, s); check("R9 stream status", s, 8'h0E);
        wait_done(ok); check("R9 stream done", ok, 1);
        rd(8'h00, s); check("R3 finished status", s, 8'h0D);
        rd32(8'h10, v); check("R9 stored", v, 7);
        rd32(8'h14, v); check("R9 pre zero", v, 0);
        rd32(8'h18, v); check("R9 pos", v, 7);
        check("R9 strobes", strobes, 7);

        // R9: streaming with zero total finishes at once.
        wr_n(8'h10, 4, 0);
        start_cap();
        rd(8'h00, s); check("R9 zero total", s, 8'h0D);
        rd32(8'h18, v); check("R9 zero pos", v, 0);
        wr(8'h03, 8'h00);

        // R4/R6/R7/R8: memory-mode vector walk.
        for (int i = 0; i < NV; i++) begin
            wr_n(8'h1E, 2, V_DIV[i]);
            wr_n(8'h10, 4, V_TOT[i]);
            wr_n(8'h14, 4, V_PRE[i]);
            wr(8'h18, 8'hA5); wr(8'h19, 8'h5A);       // R8 ignored bytes
            wr_n(8'h1A, 4, 32'hDEAD_BEEF);            // R8 split ignored
            start_cap();
            seen = 0; pre_seen = 0;
            for (int c = 0; c < 2000; c++) begin
                if (seen == V_K[i]) begin
                    pre_seen = V_K[i] + int'(sample_en);
                    trig_in = 1'b1;
                    @(negedge clk);
                    trig_in = 1'b0;
                    break;
                end
                seen += int'(sample_en);
                @(negedge clk);
            end
            lim = (V_PRE[i] < V_TOT[i]) ? V_PRE[i] : V_TOT[i];
            npre = (pre_seen < lim) ? pre_seen : lim;
            wait_done(ok); check($sformatf("R6 vec%0d done", i), ok, 1);
            rd32(8'h10, t); check($sformatf("R7 vec%0d stored", i), t, V_TOT[i]);
            rd32(8'h14, p); check($sformatf("R4 vec%0d pre", i), p, npre);
            rd32(8'h18, v);
            check($sformatf("R7 vec%0d pos", i), v, pre_seen + V_TOT[i] - npre);
            check($sformatf("R5 vec%0d strobes", i), strobes, pre_seen + V_TOT[i] - npre);
            repeat (6) @(negedge clk);
            check($sformatf("R6 vec%0d no more strobes", i), strobes, v);
            rd(8'h00, s); check($sformatf("R3 vec%0d status", i), s, 8'h0D);
        end

        summary_done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule